// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst into a synchronous SRAM. A controller presents a full address together with a load strobe. The block captures the address and then steps through the four beats of the burst. The address bits above the two least significant bits stay fixed for the whole burst. The two low bits follow one of two orderings, and the ordering is chosen when the burst is loaded.

The block uses two orderings. The interleaved order flips bits of the starting word by a beat count. The linear order counts upward from the starting word and wraps inside its aligned group of four. The load strobe has priority. When load is idle, an active-low advance strobe moves the burst on by one beat. If neither strobe is active, the burst is suspended and the present address is reused. The output is registered state mapped through a small combinational network, so a strobe sampled on one rising edge shows on the output after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the stored address, the ordering and the beat count are cleared, so `addr_o` reads all zeros after that edge.
- R2: When `load_i` is high at a rising edge, `addr_o` equals `addr_i` after that edge (first beat of a new burst).
- R3: `load_i` wins over `adv_n_i`: a load with `adv_n_i` low still gives the first beat, not the second.
- R4: With `order_i` = 0 (interleaved) at load, the low two bits run 00-01-10-11 from start 00, 01-00-11-10 from 01, 10-11-00-01 from 10 and 11-10-01-00 from 11.
- R5: With `order_i` = 1 (linear) at load, the low two bits run 00-01-10-11 from 00, 01-10-11-00 from 01, 10-11-00-01 from 10 and 11-00-01-10 from 11.
- R6: With `load_i` low and `adv_n_i` low at a rising edge, `addr_o` moves to the next beat of its sequence.
- R7: With `load_i` low and `adv_n_i` high at a rising edge, `addr_o` is unchanged (burst suspended).
- R8: Advancing from the fourth beat returns to the first beat of the same sequence.
- R9: Bits of `addr_o` above bit 1 change only on a load or a reset.
- R10: `order_i` is sampled only on a load. Changing it during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture `addr_i` and `order_i` and begin a burst |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| order_i | input | 1 | Burst ordering: 0 interleaved, 1 linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current beat address |

## Verification
The bench runs all four starting words in both orderings. A design that used the wrong sequence, for example linear where interleaved was asked, would give a mismatched second or fourth beat. It advances past the fourth beat to catch a counter that saturates instead of wrapping, or one that carries into bit 2. It asserts load and advance in the same cycle, which exposes a design that lets advance win and skips the first beat. It flips the ordering input in the middle of a burst, which exposes a design that reads the ordering live rather than latching it. Long suspends expose a counter that drifts while the advance strobe is high.

// File: rtl/bseq_pkg.sv
// Shared types for the burst address sequencer.
package bseq_pkg;
    // Burst ordering selected at load time.
    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } order_e;
endpackage

// File: rtl/bseq_start_reg.sv
// Holds the burst start address and its ordering.
// Assumes: load is a single-cycle qualifier; reset is synchronous, active low.
module bseq_start_reg
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o,
    output order_e            order_o
);
    // Capture the start address and ordering on a load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            order_o <= ORD_INTERLEAVE;
        end else if (load_i) begin
            base_o  <= addr_i;
            order_o <= order_e'(order_i);
        end
    end

    // R10
    order_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(order_o));
endmodule

// File: rtl/bseq_beat_ctr.sv
// Counts burst beats. A load restarts at the first beat. An active-low
// advance steps the count and wraps after the last beat. Otherwise it holds.
// Assumes: load has priority over advance.
module bseq_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    output logic [BEAT_W-1:0] beat_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

    // Restart, step or hold the beat count.
    always_ff @(posedge clk) begin
        if (!rst_n)        beat_o <= '0;
        else if (load_i)   beat_o <= '0;
        else if (!adv_n_i) beat_o <= beat_o + 1'b1;
    end

    // R3
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> beat_o == '0);
    // R7
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(beat_o));
    // R8
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && beat_o == LAST_BEAT) |=> beat_o == '0);
endmodule

// File: rtl/bseq_addr_map.sv
// Maps start address, ordering and beat count to the current address.
// The upper bits pass through unchanged. The low bits are either XORed
// with the beat (interleaved) or summed with it modulo the burst length (linear).
// Assumes: purely combinational; BEAT_W < ADDR_W.
module bseq_addr_map
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  order_e            order_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [BEAT_W-1:0] low_il;
    logic [BEAT_W-1:0] low_lin;

    // Per-bit flip of the start word for the interleaved order.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_il
        assign low_il[b] = base_i[b] ^ beat_i[b];
    end

    // Wrapping sum for the linear order.
    assign low_lin = base_i[BEAT_W-1:0] + beat_i;

    // Select the ordering and keep the upper bits.
    always_comb begin
        addr_o = base_i;
        addr_o[BEAT_W-1:0] = (order_i == ORD_LINEAR) ? low_lin : low_il;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top. Loads a start address and ordering, then
// produces the beat address for each beat of the burst.
// Assumes: synchronous active-low reset; load outranks advance.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] base;
    order_e            order_q;
    logic [BEAT_W-1:0] beat;

    bseq_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .order_i(order_i),
        .addr_i(addr_i), .base_o(base), .order_o(order_q)
    );

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
        .beat_o(beat)
    );

    bseq_addr_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
        .base_i(base), .order_i(order_q), .beat_i(beat), .addr_o(addr_o)
    );

    // R2
    load_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(addr_i));
    // R7
    addr_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(addr_o));
    // R9
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
    // R6
    advance_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i) |=> addr_o[BEAT_W-1:0] != $past(addr_o[BEAT_W-1:0]));
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          order_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
        .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o)
    );

    always #2 clk = ~clk;  // 250 MHz

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;
    item_t sbq[$];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Sequence tables from R4 and R5, indexed [start][beat]
    localparam logic [1:0] IL_T [4][4] = '{
        '{2'd0, 2'd1, 2'd2, 2'd3}, '{2'd1, 2'd0, 2'd3, 2'd2},
        '{2'd2, 2'd3, 2'd0, 2'd1}, '{2'd3, 2'd2, 2'd1, 2'd0}};
    localparam logic [1:0] LN_T [4][4] = '{
        '{2'd0, 2'd1, 2'd2, 2'd3}, '{2'd1, 2'd2, 2'd3, 2'd0},
        '{2'd2, 2'd3, 2'd0, 2'd1}, '{2'd3, 2'd0, 2'd1, 2'd2}};

    logic [AW-1:0] m_base = '0;
    logic          m_ord  = 1'b0;
    int            m_beat = 0;

    // Driver: apply one cycle of stimulus and queue the expected address
    task automatic step(input logic rst, input logic ld, input logic adv_n,
                        input logic ord, input logic [AW-1:0] a, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = ~rst; load_i = ld; adv_n_i = adv_n; order_i = ord; addr_i = a;
        if (rst) begin
            m_base = '0; m_ord = 1'b0; m_beat = 0;
        end else if (ld) begin
            m_base = a; m_ord = ord; m_beat = 0;
        end else if (!adv_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        it.exp = m_base;
        it.exp[1:0] = m_ord ? LN_T[m_base[1:0]][m_beat] : IL_T[m_base[1:0]][m_beat];
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare each result just after the edge that produces it
    always @(posedge clk) begin
        item_t it;
        #1;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            total++;
            if (addr_o !== it.exp) begin
                bad++;
                $display("FAIL %s: addr_o=%h expected=%h", it.tag, addr_o, it.exp);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R6: watchdog expired, got=stall expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        // R1 reset state
        repeat (3) step(1, 0, 1, 0, 20'hFFFFF, "R1");
        // R4 / R5: every start in both orderings, four beats then a wrap (R8)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                a = {18'h2A5C3 + 18'(s * 7 + m), 2'(s)};
                step(0, 1, 1, m[0], a, "R2");
                for (int b = 1; b < 4; b++)
                    step(0, 0, 0, ~m[0], 20'h0, m ? "R5" : "R4");
                step(0, 0, 0, m[0], 20'h0, "R8");
                step(0, 0, 0, m[0], 20'h0, "R6");
            end
        end
        // R7 suspend mid-burst, then resume
        step(0, 1, 1, 1, 20'h1234E, "R2");
        step(0, 0, 0, 1, 20'hFFFFF, "R6");
        repeat (4) step(0, 0, 1, 0, 20'hABCDF, "R7");
        step(0, 0, 0, 0, 20'h0, "R6");
        // R3 load and advance together
        step(0, 1, 0, 0, 20'h55551, "R3");
        step(0, 1, 0, 1, 20'h77773, "R3");
        step(0, 0, 0, 1, 20'h0, "R9");
        // R10 ordering flipped during a burst
        step(0, 1, 1, 1, 20'h0F0F2, "R2");
        step(0, 0, 0, 0, 20'h0, "R10");
        step(0, 0, 0, 0, 20'h0, "R10");
        step(0, 0, 1, 1, 20'h0, "R10");
        step(0, 0, 0, 1, 20'h0, "R10");
        // R9 upper bits fixed across wrap with all-ones start
        step(0, 1, 1, 0, 20'hFFFFF, "R2");
        repeat (5) step(0, 0, 0, 0, 20'h0, "R9");
        // R1 reset mid-burst
        step(1, 0, 0, 1, 20'h0, "R1");
        step(0, 0, 0, 1, 20'h0, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule